// File: doc/BRIEF.md
# Multi-Source Bus Reset Generator

This block drives the reset of an on-chip peripheral bus and of the processor attached to it, all in a single clock domain. When the device starts, with every flop loaded from its initial value, the bus reset is held high for a fixed power-on window of 16 clock cycles. While that window is open, every outside reset request is masked.

Once the window has closed, three outside sources can reset the bus: a main system reset whose polarity is chosen by a parameter, a watchdog time-out and a debug-controller reset. Each source first passes through a two-flop synchroniser clocked by the bus clock. The synchronised requests are then combined, and a flop drives the bus reset from the result. A request held for N cycles produces exactly N cycles of bus reset, with no stretching to a minimum width.

A status output reports when the power-on window has completed.

Top module: `busrst_gen`

## Requirements
- R1: From the start, `bus_rst` is high after clock edges 0 through 15 and low after edge 16, unless a later request asserts it again.
- R2: `por_done` is low until clock edge 16. It is high from that edge onward and never falls again.
- R3: A request level applied before any edge up to and including edge 16 has no effect. A level that is still applied after the window is honoured, counting only from the first post-window sample at edge 17.
- R4: When the parameter `MAIN_ACTIVE_HIGH` is 0, the main reset requests with a low level. When it is 1, the main reset requests with a high level.
- R5: The watchdog and debug inputs are active-high, and each one can assert `bus_rst` on its own after the window.
- R6: After the window, a request level sampled at clock edge t appears on `bus_rst` after edge t+2. The two synchroniser stages and the output register account for this latency.
- R7: A request lasting N cycles produces exactly N cycles of `bus_rst`. This includes single-cycle pulses.
- R8: Requests from several sources are ORed. Overlapping requests give one continuous reset that spans their union.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| sys_rst_req | input | 1 | Main system reset request, polarity set by `MAIN_ACTIVE_HIGH` |
| wdog_rst_req | input | 1 | Watchdog time-out reset request, active-high |
| dbg_rst_req | input | 1 | Debug-controller reset request, active-high |
| bus_rst | output | 1 | Registered active-high bus reset |
| por_done | output | 1 | High once the power-on window has ended |

## Verification
The closing of the power-on window and a request in flight through the synchronisers can fall in the same cycle. The bench provokes this in two ways. It drives debug pulses that end exactly at edge 16, and it drives a watchdog level that is raised at edge 15 and held past the window. The judgement is that the debug pulses leave no trace, and that the held level shows up on `bus_rst` only from edge 19, as the sample taken at edge 17 propagates. A second instance built with the active-high main polarity checks the parameterised input under the same cycle model.

// File: rtl/busrst_pkg.sv
package busrst_pkg;

    localparam int unsigned POR_LEN_DEF    = 16;
    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam int unsigned NUM_SRC        = 3;

    // One bit per outside reset source, already normalised to active-high.
    typedef struct packed {
        logic main;
        logic wdog;
        logic debug;
    } req_vec_t;

    function automatic logic to_active_high(input logic lvl, input bit high_true);
        return high_true ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/busrst_por_timer.sv
module busrst_por_timer #(
    parameter int unsigned POR_LEN = busrst_pkg::POR_LEN_DEF
) (
    input  logic clk,
    output logic last,
    output logic done
);

    localparam int unsigned CW = $clog2(POR_LEN + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(POR_LEN - 1);
    localparam logic [CW-1:0] END_VAL  = CW'(POR_LEN);

    logic [CW-1:0] cnt    = '0;
    logic          done_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!done_q) begin
            cnt <= cnt + 1'b1;
        end
        done_q <= done_q | last;
    end

    assign last = (cnt == LAST_VAL);
    assign done = done_q;

    assert_done_sticky_R2: assert property (@(posedge clk) done_q |=> done_q)
        else $error("done flag fell after the window");

    assert_count_bound_R2: assert property (@(posedge clk) cnt <= END_VAL)
        else $error("window counter ran past its end");

    assert_done_at_end_R2: assert property (@(posedge clk) done_q |-> (cnt == END_VAL))
        else $error("done flag set with counter not at end");

endmodule

// File: rtl/busrst_sync.sv
module busrst_sync #(
    parameter int unsigned STAGES = busrst_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic en,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stg = '0;

    // All stages are cleared while disabled, so nothing sampled in the
    // masked period survives the enable edge.
    always_ff @(posedge clk) begin
        if (en) begin
            stg <= {stg[STAGES-2:0], d};
        end else begin
            stg <= '0;
        end
    end

    assign q = stg[STAGES-1];

    assert_masked_drop_R3: assert property (@(posedge clk) !en |=> !q)
        else $error("synchroniser output high after a masked cycle");

endmodule

// File: rtl/busrst_gen.sv
module busrst_gen
    import busrst_pkg::*;
#(
    parameter int unsigned MAIN_ACTIVE_HIGH = 0,
    parameter int unsigned POR_LEN          = POR_LEN_DEF,
    parameter int unsigned SYNC_STAGES      = SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic sys_rst_req,
    input  logic wdog_rst_req,
    input  logic dbg_rst_req,
    output logic bus_rst,
    output logic por_done
);

    req_vec_t           req_norm;
    logic [NUM_SRC-1:0] req_bits;
    logic [NUM_SRC-1:0] req_sync;
    logic               raw_any;
    logic               any_req;
    logic               win_last;
    logic               win_done;
    logic               bus_rst_q = 1'b1;

    always_comb begin
        req_norm.main  = to_active_high(sys_rst_req, MAIN_ACTIVE_HIGH != 0);
        req_norm.wdog  = to_active_high(wdog_rst_req, 1'b1);
        req_norm.debug = to_active_high(dbg_rst_req, 1'b1);
    end

    assign req_bits = req_norm;
    assign raw_any  = |req_bits;

    busrst_por_timer #(.POR_LEN(POR_LEN)) u_timer (
        .clk  (clk),
        .last (win_last),
        .done (win_done)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        busrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .en  (win_done),
            .d   (req_bits[i]),
            .q   (req_sync[i])
        );
    end

    assign any_req = |req_sync;

    always_ff @(posedge clk) begin
        bus_rst_q <= (~win_done & ~win_last) | any_req;
    end

    assign bus_rst  = bus_rst_q;
    assign por_done = win_done;

    assert_window_high_R1: assert property (@(posedge clk) !por_done |-> bus_rst)
        else $error("bus reset low inside power-on window");

    assert_release_R1: assert property (@(posedge clk) $rose(por_done) |-> !bus_rst)
        else $error("bus reset not released at window end");

    assert_follow_R6: assert property (@(posedge clk)
        (por_done && $past(por_done, 3)) |-> (bus_rst == $past(raw_any, 3)))
        else $error("bus reset does not follow delayed request");

endmodule

// File: tb/sim_busrst_gen.sv
`timescale 1ns/1ps
module sim_busrst_gen;

    localparam int NCYC = 230;

    logic clk = 1'b0;
    logic sys_n = 1'b1, wdt = 1'b0, dbg = 1'b0;
    logic sys_hi = 1'b0;
    logic rst0, done0, rst1, done1;

    logic rq0 [0:NCYC];
    logic rq1 [0:NCYC];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    busrst_gen u0 (
        .clk(clk), .sys_rst_req(sys_n), .wdog_rst_req(wdt), .dbg_rst_req(dbg),
        .bus_rst(rst0), .por_done(done0)
    );

    busrst_gen #(.MAIN_ACTIVE_HIGH(1)) u1 (
        .clk(clk), .sys_rst_req(sys_hi), .wdog_rst_req(1'b0), .dbg_rst_req(1'b0),
        .bus_rst(rst1), .por_done(done1)
    );

    task automatic set_inputs(input int t);
        sys_n  = 1'b1;
        wdt    = 1'b0;
        dbg    = 1'b0;
        sys_hi = 1'b0;
        if (t >= 3 && t <= 5)   sys_n = 1'b0;
        if (t == 8)             wdt = 1'b1;
        if (t >= 12 && t <= 16) dbg = 1'b1;
        if (t >= 15 && t <= 20) wdt = 1'b1;
        if (t == 30)            sys_n = 1'b0;
        if (t >= 40 && t <= 44) wdt = 1'b1;
        if (t >= 42 && t <= 50) dbg = 1'b1;
        if (t >= 60 && t <= 66) sys_n = 1'b0;
        if (t == 63)            dbg = 1'b1;
        for (int k = 0; k < 12; k++) begin
            int st, w;
            st = 80 + k * 10;
            w  = 1 + (k % 6);
            if (t >= st && t < st + w) begin
                case (k % 3)
                    0: sys_n = 1'b0;
                    1: wdt   = 1'b1;
                    default: dbg = 1'b1;
                endcase
            end
        end
        if (t >= 5 && t <= 9)     sys_hi = 1'b1;
        if (t >= 100 && t <= 103) sys_hi = 1'b1;
        if (t >= 210 && t <= 212) sys_hi = 1'b1;
    endtask

    function automatic string tag_of(input int t);
        if (t < 16)                 return "R1";
        if (t < 19)                 return "R3";
        if (t <= 25)                return "R6";
        if (t >= 40 && t <= 55)     return "R8";
        if (t >= 80 && t <= 200)    return "R7";
        return "R5";
    endfunction

    function automatic logic expect_rst(input int t, input logic hist [0:NCYC]);
        if (t < 16) return 1'b1;
        if (t < 19) return 1'b0;
        return hist[t-2];
    endfunction

    task automatic check(input string tag, input string what, input int t,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d actual %b expected %b", tag, what, t, act, exp);
        end
    endtask

    initial begin
        set_inputs(1);
        #5;
        check("R1", "bus_rst u0 at start", 0, rst0, 1'b1);
        check("R2", "por_done at start", 0, done0, 1'b0);
        for (int t = 1; t <= NCYC; t++) begin
            rq0[t] = ~sys_n | wdt | dbg;
            rq1[t] = sys_hi;
            @(posedge clk);
            @(negedge clk);
            check(tag_of(t), "bus_rst u0", t, rst0, expect_rst(t, rq0));
            check("R4", "bus_rst u1", t, rst1, expect_rst(t, rq1));
            check("R2", "por_done", t, done0, (t >= 16) ? 1'b1 : 1'b0);
            if (t < NCYC) set_inputs(t + 1);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule